// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt Flag

This block paces the slow-rate housekeeping of a retro-console sound unit. It counts CPU clock cycles and, at fixed step points, emits one-cycle quarter-frame and half-frame strobes. Envelope, sweep and length-counter logic elsewhere in the unit consume these strobes. It runs one of two step sequences: a four-step loop that also raises a frame interrupt flag, and a five-step loop that never does.

The CPU programs the block through a single control-register write port. Bit 7 of the written byte selects the sequence and bit 6 inhibits the interrupt. Every write restarts the sequence. The CPU polls a status byte and signals the read with a strobe, and each read clears the frame flag. The CPU interrupt line is shared with a sample-playback channel, whose request comes in as two inputs. The line therefore stays asserted while that channel still requests service, even after the frame flag has been cleared.

The spacing between step points is the parameter `STEP_CYCLES`, so a test can run whole sequences in a few dozen cycles.

Top module: `fseq_top`

## Requirements
- R1: `ctl_data` bit 7, written with `ctl_wr`, selects the sequence: 0 selects four-step and 1 selects five-step. The new mode governs every step that follows the write.
- R2: A control write restarts the cycle counter. The first step strobe after a write is visible after the `STEP_CYCLES`-th rising edge following the write edge. A step that would fall on the write edge is suppressed.
- R3: In four-step mode, steps occur every `STEP_CYCLES` edges and the sequence repeats after step 4. `qtr_stb` pulses for one cycle on steps 1, 2, 3 and 4. `half_stb` pulses on steps 2 and 4.
- R4: In five-step mode, the sequence repeats after step 5. `qtr_stb` pulses on steps 1, 2, 3 and 5. `half_stb` pulses on steps 2 and 5. Step 4 produces no strobe.
- R5: A control write with bit 7 set makes `qtr_stb` and `half_stb` both high for the single cycle that follows the write edge. A write with bit 7 clear produces no strobe in that cycle.
- R6: The frame flag is set on step 4 of the four-step sequence, provided interrupt inhibit is clear. The five-step sequence never sets the flag.
- R7: A control write with bit 6 set clears the frame flag at the write edge. While bit 6 remains set, the flag stays clear.
- R8: `stat_data` is combinational. Bit 6 carries the frame flag and all other bits read 0. A cycle with `stat_rd` high clears the flag at its edge, unless a flag-setting step falls on that same edge, in which case the flag stays set.
- R9: `cpu_irq` is high whenever the frame flag is set, or `smp_left` and `smp_irq_en` are both high. Clearing the frame flag does not drop `cpu_irq` while the sample channel is requesting.
- R10: While `rst` is high at a clock edge, the block returns to four-step mode with inhibit clear, the counter at zero, the flag clear and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control byte: bit 7 selects the mode, bit 6 is interrupt inhibit |
| stat_rd | input | 1 | Status read strobe; clears the frame flag |
| stat_data | output | 8 | Status byte; bit 6 is the frame flag |
| smp_left | input | 1 | Sample channel has bytes remaining |
| smp_irq_en | input | 1 | Sample channel interrupt enable |
| qtr_stb | output | 1 | Quarter-frame strobe, one cycle |
| half_stb | output | 1 | Half-frame strobe, one cycle |
| cpu_irq | output | 1 | Combined interrupt request to the CPU |

## Verification
The properties assume that `ctl_wr`, `stat_rd` and the two sample-channel inputs are free of X and are sampled as single-cycle or level values at the rising edge. Apart from that, no ordering between them is assumed. The flag-clear checks allow for a flag-setting step landing on the same edge as a read: they accept the flag staying high only when both strobes pulse together. The bench drives every input at the falling edge and keeps each write and read strobe high for exactly one edge. It deliberately places a read on the edge that sets the flag, and a write on the edge where a step would otherwise fire.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic {
        SEQ_FOUR = 1'b0,
        SEQ_FIVE = 1'b1
    } seq_mode_e;

    localparam int CTL_MODE_BIT  = 7;
    localparam int CTL_INH_BIT   = 6;
    localparam int STAT_FLAG_BIT = 6;

    typedef logic [2:0] step_t;

    typedef struct packed {
        seq_mode_e mode;
        logic      inhibit;
    } ctl_t;

    typedef struct packed {
        logic qtr;
        logic half;
        logic flag_set;
    } step_act_t;

    function automatic step_t seq_len(seq_mode_e m);
        return (m == SEQ_FIVE) ? step_t'(5) : step_t'(4);
    endfunction

    function automatic step_act_t step_action(seq_mode_e m, step_t s);
        step_act_t a;
        a = '0;
        if (m == SEQ_FOUR) begin
            unique case (s)
                3'd1: a = '{qtr: 1'b1, half: 1'b0, flag_set: 1'b0};
                3'd2: a = '{qtr: 1'b1, half: 1'b1, flag_set: 1'b0};
                3'd3: a = '{qtr: 1'b1, half: 1'b0, flag_set: 1'b0};
                3'd4: a = '{qtr: 1'b1, half: 1'b1, flag_set: 1'b1};
                default: a = '0;
            endcase
        end else begin
            unique case (s)
                3'd1: a = '{qtr: 1'b1, half: 1'b0, flag_set: 1'b0};
                3'd2: a = '{qtr: 1'b1, half: 1'b1, flag_set: 1'b0};
                3'd3: a = '{qtr: 1'b1, half: 1'b0, flag_set: 1'b0};
                3'd5: a = '{qtr: 1'b1, half: 1'b1, flag_set: 1'b0};
                default: a = '0;
            endcase
        end
        return a;
    endfunction

    function automatic logic [7:0] pack_status(logic flag);
        logic [7:0] v;
        v = '0;
        v[STAT_FLAG_BIT] = flag;
        return v;
    endfunction

endpackage

// File: rtl/fseq_ctl.sv
module fseq_ctl
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] data,
    output ctl_t       ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{mode: SEQ_FOUR, inhibit: 1'b0};
        end else if (wr) begin
            ctl.mode    <= seq_mode_e'(data[CTL_MODE_BIT]);
            ctl.inhibit <= data[CTL_INH_BIT];
        end
    end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import fseq_pkg::*;
#(
    parameter int STEP_CYCLES = 7457
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  seq_mode_e mode,
    output logic      tick,
    output step_t     fired
);
    localparam int          CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cyc;
    step_t            done;

    assign fired = done + step_t'(1);
    assign tick  = (cyc == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cyc  <= '0;
            done <= '0;
        end else if (cyc == LAST) begin
            cyc  <= '0;
            done <= (fired >= seq_len(mode)) ? step_t'(0) : fired;
        end else begin
            cyc <= cyc + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fseq_strobe.sv
module fseq_strobe
    import fseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  step_t     fired,
    input  seq_mode_e mode,
    input  logic      imm,
    output logic      qtr_stb,
    output logic      half_stb,
    output logic      flag_evt
);
    step_act_t act;

    assign act      = step_action(mode, fired);
    assign flag_evt = tick && act.flag_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            qtr_stb  <= 1'b0;
            half_stb <= 1'b0;
        end else if (imm) begin
            qtr_stb  <= 1'b1;
            half_stb <= 1'b1;
        end else if (tick) begin
            qtr_stb  <= act.qtr;
            half_stb <= act.half;
        end else begin
            qtr_stb  <= 1'b0;
            half_stb <= 1'b0;
        end
    end
endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic inhibit,
    input  logic clr,
    input  logic smp_left,
    input  logic smp_irq_en,
    output logic flag,
    output logic cpu_irq
);
    logic smp_req;

    assign smp_req = smp_left && smp_irq_en;
    assign cpu_irq = flag || smp_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt && !inhibit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int STEP_CYCLES = 7457
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_data,
    input  logic       stat_rd,
    output logic [7:0] stat_data,
    input  logic       smp_left,
    input  logic       smp_irq_en,
    output logic       qtr_stb,
    output logic       half_stb,
    output logic       cpu_irq
);
    ctl_t  ctl;
    logic  tick;
    step_t fired;
    logic  flag_evt;
    logic  flag;
    logic  wr_five;
    logic  wr_inh;

    assign wr_five = ctl_wr && ctl_data[CTL_MODE_BIT];
    assign wr_inh  = ctl_wr && ctl_data[CTL_INH_BIT];

    fseq_ctl u_ctl (
        .clk (clk),
        .rst (rst),
        .wr  (ctl_wr),
        .data(ctl_data),
        .ctl (ctl)
    );

    fseq_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(ctl_wr),
        .mode   (ctl.mode),
        .tick   (tick),
        .fired  (fired)
    );

    fseq_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .fired   (fired),
        .mode    (ctl.mode),
        .imm     (wr_five),
        .qtr_stb (qtr_stb),
        .half_stb(half_stb),
        .flag_evt(flag_evt)
    );

    fseq_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_evt   (flag_evt),
        .inhibit   (ctl.inhibit),
        .clr       (stat_rd || wr_inh),
        .smp_left  (smp_left),
        .smp_irq_en(smp_irq_en),
        .flag      (flag),
        .cpu_irq   (cpu_irq)
    );

    assign stat_data = pack_status(flag);
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_data,
    input logic       stat_rd,
    input logic [7:0] stat_data,
    input logic       smp_left,
    input logic       smp_irq_en,
    input logic       qtr_stb,
    input logic       half_stb,
    input logic       cpu_irq
);
    p_half_with_qtr_r3: assert property (@(posedge clk) disable iff (rst)
        half_stb |-> qtr_stb);

    p_wr_five_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_data[7]) |=> (qtr_stb && half_stb));

    p_wr_four_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_data[7]) |=> (!qtr_stb && !half_stb));

    p_flag_rise_on_half_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_data[6]) |-> (half_stb && qtr_stb));

    p_inhibit_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_data[6]) |=> !stat_data[6]);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (!stat_data[6] || (qtr_stb && half_stb)));

    p_status_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_data & 8'hBF) == 8'h00);

    p_smp_holds_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (smp_left && smp_irq_en) |-> cpu_irq);

    p_irq_follows_flag_r9: assert property (@(posedge clk) disable iff (rst)
        !(smp_left && smp_irq_en) |-> (cpu_irq == stat_data[6]));
endmodule

bind fseq_top fseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_data  (ctl_data),
    .stat_rd   (stat_rd),
    .stat_data (stat_data),
    .smp_left  (smp_left),
    .smp_irq_en(smp_irq_en),
    .qtr_stb   (qtr_stb),
    .half_stb  (half_stb),
    .cpu_irq   (cpu_irq)
);

// File: tb/tb_fseq_top.sv
module tb_fseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = 8'h00;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_data;
    logic       smp_left = 1'b0;
    logic       smp_irq_en = 1'b0;
    logic       qtr_stb;
    logic       half_stb;
    logic       cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fseq_top #(.STEP_CYCLES(P)) dut (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_data  (ctl_data),
        .stat_rd   (stat_rd),
        .stat_data (stat_data),
        .smp_left  (smp_left),
        .smp_irq_en(smp_irq_en),
        .qtr_stb   (qtr_stb),
        .half_stb  (half_stb),
        .cpu_irq   (cpu_irq)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        ctl_wr   = 1'b1;
        ctl_data = v;
        tick();
        ctl_wr   = 1'b0;
        ctl_data = 8'h00;
    endtask

    task automatic rd();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    function automatic int step_at(bit five, int i);
        if (i == 0 || (i % P) != 0) return 0;
        return ((i / P) - 1) % (five ? 5 : 4) + 1;
    endfunction

    function automatic logic exp_q(bit five, int i);
        int s;
        if (i == 0) return five;
        s = step_at(five, i);
        if (s == 0) return 1'b0;
        return five ? (s != 4) : 1'b1;
    endfunction

    function automatic logic exp_h(bit five, int i);
        int s;
        if (i == 0) return five;
        s = step_at(five, i);
        return five ? (s == 2 || s == 5) : (s == 2 || s == 4);
    endfunction

    task automatic run_pattern(string req, bit five, int n, bit flag_on);
        chk(req, "qtr at write", qtr_stb, exp_q(five, 0));
        chk(req, "half at write", half_stb, exp_h(five, 0));
        for (int i = 1; i <= n; i++) begin
            tick();
            if (qtr_stb !== exp_q(five, i) || half_stb !== exp_h(five, i)) begin
                chk(req, $sformatf("strobes cycle %0d", i), {qtr_stb, half_stb},
                    {exp_q(five, i), exp_h(five, i)});
            end
            if (i % P == 0) begin
                chk(req, $sformatf("strobes step cycle %0d", i), {qtr_stb, half_stb},
                    {exp_q(five, i), exp_h(five, i)});
                chk("R6", $sformatf("flag cycle %0d", i), stat_data,
                    (flag_on && !five && i >= 4 * P) ? 8'h40 : 8'h00);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R10", "strobes in reset", {qtr_stb, half_stb}, 8'h00);
        chk("R10", "status in reset", stat_data, 8'h00);
        chk("R10", "irq in reset", cpu_irq, 8'h00);
        rst = 1'b0;
        for (int i = 1; i < P; i++) tick();
        chk("R10", "no strobe before first step", qtr_stb, 8'h00);
        tick();
        chk("R10", "four-step step 1 after reset", {qtr_stb, half_stb}, 8'h02);
    endtask

    task automatic t_four();
        wr(8'h00);
        run_pattern("R3", 1'b0, 8 * P, 1'b1);
        chk("R9", "irq follows flag", cpu_irq, 8'h01);
        chk("R8", "status before read", stat_data, 8'h40);
        rd();
        chk("R8", "status after read", stat_data, 8'h00);
        chk("R9", "irq after read", cpu_irq, 8'h00);
    endtask

    task automatic t_five();
        wr(8'h80);
        chk("R5", "immediate strobes", {qtr_stb, half_stb}, 8'h03);
        run_pattern("R4", 1'b1, 10 * P, 1'b0);
        chk("R1", "five-step sets no flag", stat_data, 8'h00);
        wr(8'h00);
        chk("R1", "back to four-step no immediate strobe", {qtr_stb, half_stb}, 8'h00);
    endtask

    task automatic t_inhibit();
        wr(8'h00);
        repeat (4 * P) tick();
        chk("R6", "flag set at step 4", stat_data, 8'h40);
        wr(8'h40);
        chk("R7", "inhibit write clears flag", stat_data, 8'h00);
        chk("R7", "irq dropped", cpu_irq, 8'h00);
        repeat (8 * P) tick();
        chk("R7", "flag stays clear while inhibited", stat_data, 8'h00);
        wr(8'h00);
    endtask

    task automatic t_shared();
        smp_left = 1'b1;
        smp_irq_en = 1'b0;
        #1;
        chk("R9", "sample bytes without enable", cpu_irq, 8'h00);
        smp_irq_en = 1'b1;
        #1;
        chk("R9", "sample request raises irq", cpu_irq, 8'h01);
        smp_left = 1'b0;
        smp_irq_en = 1'b0;
        wr(8'h00);
        repeat (4 * P) tick();
        smp_left = 1'b1;
        smp_irq_en = 1'b1;
        rd();
        chk("R8", "read clears flag", stat_data, 8'h00);
        chk("R9", "irq held by sample channel after read", cpu_irq, 8'h01);
        smp_left = 1'b0;
        #1;
        chk("R9", "irq released when sample idle", cpu_irq, 8'h00);
        wr(8'h00);
        repeat (4 * P) tick();
        smp_left = 1'b1;
        wr(8'h40);
        chk("R7", "inhibit clears flag", stat_data, 8'h00);
        chk("R9", "irq held by sample channel after inhibit", cpu_irq, 8'h01);
        smp_irq_en = 1'b0;
        #1;
        chk("R9", "irq released when enable drops", cpu_irq, 8'h00);
        smp_left = 1'b0;
        wr(8'h00);
    endtask

    task automatic t_set_wins();
        wr(8'h00);
        repeat (4 * P - 1) tick();
        chk("R8", "flag clear before step 4", stat_data, 8'h00);
        rd();
        chk("R8", "set wins over same-edge read", stat_data, 8'h40);
        rd();
        chk("R8", "later read clears", stat_data, 8'h00);
    endtask

    task automatic t_restart();
        wr(8'h00);
        repeat (2) tick();
        wr(8'h00);
        for (int i = 1; i < P; i++) begin
            tick();
            chk("R2", $sformatf("no strobe cycle %0d after restart", i), qtr_stb, 8'h00);
        end
        tick();
        chk("R2", "step 1 after restart", {qtr_stb, half_stb}, 8'h02);
        repeat (P - 1) tick();
        wr(8'h00);
        chk("R2", "step on write edge suppressed", {qtr_stb, half_stb}, 8'h00);
        repeat (P) tick();
        chk("R2", "counting resumes from write", {qtr_stb, half_stb}, 8'h02);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_four();
        t_five();
        t_inhibit();
        t_shared();
        t_set_wins();
        t_restart();
        finish_run();
    end
endmodule